// File: doc/BRIEF.md
# Return Address Stack with Checkpoint Repair

This block predicts return targets for a speculative fetch front end. A call pushes its own address. A return that is predicted taken reads the top entry as its target and then pops it. The stack is a circular buffer of `DEPTH` slots with one hardware thread. A push into a full stack overwrites the oldest slot, and the top pointer wraps modulo `DEPTH`.

The top slot index and the address held there are always visible as combinational outputs. They show the state before any operation of the current cycle. Fetch logic saves both values alongside a return prediction. When that prediction is later squashed, a repair operation writes the saved address back into the saved slot and moves the top pointer there. The contents and the pointer therefore come back exactly, even if a wrong-path call has overwritten the slot since. A call that was pushed on the wrong path, or that resolved not taken, is undone with a single pop.

The block does not decode instructions and does not decide when to push or pop. An occupancy count drives optional empty and full flags.

Top module: `ras_repair`

## Requirements
- R1: After reset, top_idx_o is 0, top_addr_o is 0, empty_o is 1 and full_o is 0.
- R2: A push alone moves top_idx_o to (old index + 1) mod DEPTH on the next cycle, and top_addr_o then equals the pushed address.
- R3: A pop alone on a non-empty stack moves top_idx_o to (old index - 1) mod DEPTH on the next cycle and reduces the occupancy by one. During the cycle in which the pop is requested, top_idx_o and top_addr_o still show the pre-pop top.
- R4: A pop on an empty stack leaves top_idx_o, top_addr_o and the occupancy unchanged, and empty_o stays 1.
- R5: A push on a full stack (occupancy DEPTH) still advances and wraps the pointer. It overwrites the slot that held the oldest entry, and full_o stays 1.
- R6: A repair writes repair_addr_i into slot repair_idx_i and sets top_idx_o to repair_idx_i. On the next cycle, top_addr_o equals repair_addr_i.
- R7: On repair, the occupancy becomes the old occupancy plus the signed circular distance from the old top to repair_idx_i. That distance is taken as an IDX_W-bit two's complement value, in the range -DEPTH/2 to DEPTH/2-1. The result is clamped to the range 1 to DEPTH.
- R8: When several requests arrive in the same cycle, only one takes effect, with priority repair over pop over push. Requests that lose are dropped with no effect.
- R9: empty_o is 1 exactly when the occupancy is 0, and full_o is 1 exactly when it is DEPTH. Both are tied to 0 when HAS_FLAGS is 0.
- R10: A push followed by one pop returns top_idx_o and top_addr_o to their values before the push, provided the stack was not full at the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push request (call) |
| push_addr_i | input | AW | Address to push |
| pop_i | input | 1 | Pop request (predicted return, or undo of a call) |
| repair_i | input | 1 | Repair request |
| repair_idx_i | input | IDX_W | Saved slot index to restore |
| repair_addr_i | input | AW | Saved address to restore |
| top_idx_o | output | IDX_W | Current top slot index, pre-operation |
| top_addr_o | output | AW | Address in the top slot, pre-operation |
| empty_o | output | 1 | Occupancy is zero |
| full_o | output | 1 | Occupancy equals DEPTH |

## Verification
The hardest state to reach is the occupancy clamp during repair. Reaching it needs a full stack that has wrapped, or an empty one, together with a repair index whose circular distance from the top points past either bound. Directed sequences first overfill the stack by several pushes. They then issue repairs at indices behind and ahead of the wrapped top, and drain the stack to empty before repairing again. Random traffic with a push-heavy mix then revisits the wrap and the clamps while repair, pop and push collide in the same cycles.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_FIX  = 2'd3
  } ras_op_e;
endpackage

// File: rtl/ras_op_sel.sv
module ras_op_sel
  import ras_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  input  logic    repair_i,
  output ras_op_e op_o
);
  // repair > pop > push
  always_comb begin
    if (repair_i)    op_o = OP_FIX;
    else if (pop_i)  op_o = OP_POP;
    else if (push_i) op_o = OP_PUSH;
    else             op_o = OP_NONE;
  end
endmodule

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ras_op_e          op_i,
  input  logic [IDX_W-1:0] fix_idx_i,
  output logic [IDX_W-1:0] tp_o,
  output logic [CW-1:0]    cnt_o,
  output logic             we_o,
  output logic [IDX_W-1:0] widx_o
);
  localparam int SW = CW + 2;
  localparam logic signed [SW-1:0] ONE_S  = SW'(1);
  localparam logic signed [SW-1:0] FULL_S = SW'(DEPTH);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [IDX_W-1:0] tp_q, tp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] diff;
  logic signed [SW-1:0] sum_s;
  logic [CW-1:0] fix_cnt;

  // occupancy after repair: add signed circular distance, clamp to [1, DEPTH]
  always_comb begin
    diff  = fix_idx_i - tp_q;
    sum_s = $signed({2'b00, cnt_q}) + $signed({{(SW-IDX_W){diff[IDX_W-1]}}, diff});
    if (sum_s < ONE_S)       fix_cnt = CW'(1);
    else if (sum_s > FULL_S) fix_cnt = CNT_MAX;
    else                     fix_cnt = sum_s[CW-1:0];
  end

  always_comb begin
    tp_d   = tp_q;
    cnt_d  = cnt_q;
    we_o   = 1'b0;
    widx_o = tp_q + IDX_W'(1);
    unique case (op_i)
      OP_PUSH: begin
        tp_d  = tp_q + IDX_W'(1);
        cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CW'(1);
        we_o  = 1'b1;
      end
      OP_POP: begin
        if (cnt_q != '0) begin
          tp_d  = tp_q - IDX_W'(1);
          cnt_d = cnt_q - CW'(1);
        end
      end
      OP_FIX: begin
        tp_d   = fix_idx_i;
        cnt_d  = fix_cnt;
        we_o   = 1'b1;
        widx_o = fix_idx_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tp_q  <= '0;
      cnt_q <= '0;
    end else begin
      tp_q  <= tp_d;
      cnt_q <= cnt_d;
    end
  end

  assign tp_o  = tp_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 16,
  parameter int AW = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [AW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [AW-1:0]    rdata_o
);
  logic [AW-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0] hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign hit[g] = we_i && (widx_i == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (hit[i]) slot_q[i] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[ridx_i];
endmodule

// File: rtl/ras_repair.sv
module ras_repair
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW = 32,
  parameter bit HAS_FLAGS = 1'b1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [AW-1:0]    push_addr_i,
  input  logic             pop_i,
  input  logic             repair_i,
  input  logic [IDX_W-1:0] repair_idx_i,
  input  logic [AW-1:0]    repair_addr_i,
  output logic [IDX_W-1:0] top_idx_o,
  output logic [AW-1:0]    top_addr_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int CW = $clog2(DEPTH + 1);

  ras_op_e op;
  logic [IDX_W-1:0] tp, widx;
  logic [CW-1:0] cnt;
  logic we;
  logic [AW-1:0] wdata;

  ras_op_sel i_sel (
    .push_i  (push_i),
    .pop_i   (pop_i),
    .repair_i(repair_i),
    .op_o    (op)
  );

  ras_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .fix_idx_i(repair_idx_i),
    .tp_o     (tp),
    .cnt_o    (cnt),
    .we_o     (we),
    .widx_o   (widx)
  );

  assign wdata = (op == OP_FIX) ? repair_addr_i : push_addr_i;

  ras_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .widx_i (widx),
    .wdata_i(wdata),
    .ridx_i (tp),
    .rdata_o(top_addr_o)
  );

  assign top_idx_o = tp;

  if (HAS_FLAGS) begin : g_flags
    assign empty_o = (cnt == '0);
    assign full_o  = (cnt == CW'(DEPTH));
  end else begin : g_noflags
    assign empty_o = 1'b0;
    assign full_o  = 1'b0;
  end
endmodule

// File: rtl/ras_repair_chk.sv
module ras_repair_chk #(
  parameter int DEPTH = 16,
  parameter int AW = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic [AW-1:0]    push_addr_i,
  input logic             pop_i,
  input logic             repair_i,
  input logic [IDX_W-1:0] repair_idx_i,
  input logic [AW-1:0]    repair_addr_i,
  input logic [IDX_W-1:0] top_idx_o,
  input logic [AW-1:0]    top_addr_o,
  input logic             empty_o,
  input logic             full_o
);
  // R2
  push_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !repair_i) |=>
      (top_idx_o == $past(top_idx_o) + IDX_W'(1)) && (top_addr_o == $past(push_addr_i)));
  // R3
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !repair_i && !empty_o) |=> (top_idx_o == $past(top_idx_o) - IDX_W'(1)));
  // R4
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !repair_i && empty_o) |=> ($stable(top_idx_o) && $stable(top_addr_o) && empty_o));
  // R5
  full_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !repair_i && full_o) |=> full_o);
  // R6
  repair_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repair_i |=> (top_idx_o == $past(repair_idx_i)) && (top_addr_o == $past(repair_addr_i)));
  // R7
  repair_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repair_i |=> !empty_o);
  // R9
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));
endmodule

bind ras_repair ras_repair_chk #(.DEPTH(DEPTH), .AW(AW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .push_addr_i  (push_addr_i),
  .pop_i        (pop_i),
  .repair_i     (repair_i),
  .repair_idx_i (repair_idx_i),
  .repair_addr_i(repair_addr_i),
  .top_idx_o    (top_idx_o),
  .top_addr_o   (top_addr_o),
  .empty_o      (empty_o),
  .full_o       (full_o)
);

// File: tb/test_ras_repair.sv
module test_ras_repair;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 32;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic push, pop, fix;
  logic [AW-1:0] push_addr, fix_addr;
  logic [IDX_W-1:0] fix_idx;
  logic [IDX_W-1:0] top_idx;
  logic [AW-1:0] top_addr;
  logic empty, full;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [AW-1:0] m_mem [DEPTH];
  int m_tp, m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_repair #(.DEPTH(DEPTH), .AW(AW), .HAS_FLAGS(1'b1)) i_ras_repair (
    .clk_i(clk), .rst_ni(rst_ni),
    .push_i(push), .push_addr_i(push_addr), .pop_i(pop),
    .repair_i(fix), .repair_idx_i(fix_idx), .repair_addr_i(fix_addr),
    .top_idx_o(top_idx), .top_addr_o(top_addr), .empty_o(empty), .full_o(full)
  );

  function automatic int fix_count(int cnt, int tp, int idx);
    int d = (idx - tp) & (DEPTH - 1);
    if (d >= DEPTH/2) d -= DEPTH;
    d += cnt;
    if (d < 1) d = 1;
    if (d > DEPTH) d = DEPTH;
    return d;
  endfunction

  // model update for one clock edge: repair > pop > push
  task automatic model_step(bit p, logic [AW-1:0] pa, bit q, bit f, int fi, logic [AW-1:0] fa);
    if (f) begin
      m_cnt = fix_count(m_cnt, m_tp, fi);
      m_tp = fi;
      m_mem[fi] = fa;
    end else if (q) begin
      if (m_cnt > 0) begin
        m_tp = (m_tp + DEPTH - 1) % DEPTH;
        m_cnt--;
      end
    end else if (p) begin
      m_tp = (m_tp + 1) % DEPTH;
      m_mem[m_tp] = pa;
      if (m_cnt < DEPTH) m_cnt++;
    end
  endtask

  task automatic check_state(string tag);
    bit e_empty = (m_cnt == 0);
    bit e_full = (m_cnt == DEPTH);
    total++;
    if (top_idx !== IDX_W'(m_tp) || top_addr !== m_mem[m_tp] || empty !== e_empty || full !== e_full) begin
      bad++;
      $display("FAIL %s: idx=%0d addr=%h empty=%b full=%b expected idx=%0d addr=%h empty=%b full=%b",
               tag, top_idx, top_addr, empty, full, m_tp, m_mem[m_tp], e_empty, e_full);
    end
  endtask

  task automatic step(bit p, logic [AW-1:0] pa, bit q, bit f, int fi, logic [AW-1:0] fa, string tag);
    @(negedge clk);
    push = p; push_addr = pa; pop = q; fix = f; fix_idx = IDX_W'(fi); fix_addr = fa;
    #1;
    // R3: outputs show the pre-operation state while a request is pending
    check_state({tag, " pre-op R3"});
    model_step(p, pa, q, f, fi, fa);
    @(negedge clk);
    push = 0; pop = 0; fix = 0;
    check_state(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    int saved_idx;
    logic [AW-1:0] saved_addr;
    seed = 32'h5eed;
    void'($urandom(seed));
    push = 0; pop = 0; fix = 0; push_addr = '0; fix_addr = '0; fix_idx = '0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_tp = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_state("R1 reset");

    step(0, 0, 1, 0, 0, 0, "R4 pop empty");
    step(1, 32'h1000, 0, 0, 0, 0, "R2 push");
    step(1, 32'h1004, 0, 0, 0, 0, "R2 push");
    step(1, 32'hbeef, 0, 0, 0, 0, "R10 push");
    step(0, 0, 1, 0, 0, 0, "R10 undo pop");
    step(0, 0, 1, 0, 0, 0, "R3 pop");
    // capture checkpoint before pop, then repair
    saved_idx = m_tp; saved_addr = m_mem[m_tp];
    step(0, 0, 1, 0, 0, 0, "R3 pop");
    step(1, 32'hdead, 0, 0, 0, 0, "R2 wrong path call");
    step(0, 0, 0, 1, saved_idx, saved_addr, "R6 repair");
    step(0, 0, 1, 0, 0, 0, "R3 pop after repair");
    step(0, 0, 1, 0, 0, 0, "R4 pop to empty");
    step(0, 0, 1, 0, 0, 0, "R4 pop empty again");
    // overfill
    for (int i = 0; i < DEPTH + 5; i++) step(1, 32'h2000 + i*4, 0, 0, 0, 0, "R5 fill wrap");
    step(1, 32'h3000, 0, 0, 0, 0, "R5 push full");
    step(0, 0, 0, 1, (m_tp + 5) % DEPTH, 32'haaaa, "R7 clamp high");
    step(0, 0, 0, 1, (m_tp + DEPTH - 6) % DEPTH, 32'hbbbb, "R7 shrink");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0, "R9 drain");
    step(0, 0, 0, 1, (m_tp + DEPTH - 3) % DEPTH, 32'hcccc, "R7 clamp low");
    step(1, 32'h4444, 1, 1, 7, 32'h7777, "R8 all three");
    step(1, 32'h5555, 1, 0, 0, 0, "R8 pop over push");
    step(1, 32'h6666, 0, 1, 2, 32'h2222, "R8 repair over push");
    step(0, 0, 1, 1, 9, 32'h9999, "R8 repair over pop");

    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      bit p = (r < 55) || (r >= 90);
      bit q = (r >= 55 && r < 85) || (r >= 95);
      bit f = (r >= 85 && r < 92) || (r >= 98);
      step(p, $urandom, q, f, $urandom_range(0, DEPTH-1), $urandom, "R2/R3/R7/R8/R9 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule